// File: doc/BRIEF.md
# Debug Request and Acknowledge Control

This block sits between a processor core and the system's test port. A small three-bit control word is loaded through a serial test access port. The port has a sixteen-state controller, an instruction register and one selectable data register. The control word can force a debug request into the core, force the debug acknowledge seen by the rest of the system, and disable interrupts.

The forced request does not reach the core directly. It passes through a hold stage that follows the control bit only while the test controller sits in Run-Test/Idle. In every other controller state the stage keeps its last value. Several processors sharing one scan chain can therefore be armed one after another while they keep running. They then all enter debug on the same clock, when the chain moves into Run-Test/Idle.

The interrupt enable given to the core is low whenever the outgoing acknowledge is high, or whenever the interrupt-disable control bit is set.

Top module: `dbgc_top`

## Requirements
- R1: `irq_en` is 1 exactly when `dbgack_out` is 0 and control bit 2 (interrupt disable) is 0; otherwise it is 0.
- R2: `dbgack_out` is the OR of `core_dbgack` and control bit 0.
- R3: `dbgrq_core` is the OR of `ext_dbgrq` and the held copy of control bit 1.
- R4: The held copy of control bit 1 follows the control bit while the controller is in Run-Test/Idle. In all other states it keeps its value.
- R5: The controller follows the standard 16-state transition table on `tms` at the rising edge of `tck`. Five rising edges with `tms` high always reach Test-Logic-Reset.
- R6: The instruction register is 4 bits wide, and code 4'b1100 selects the control register. The control word is shifted in through `tdi` LSB first: bit 2 disables interrupts, bit 1 forces the request and bit 0 forces the acknowledge. It is loaded on Update-DR only while that code is selected. Any other code selects a one-bit bypass and leaves the control word unchanged.
- R7: `tdo` changes on the falling edge of `tck`, and it is 0 outside Shift-IR and Shift-DR. While shifting, it shows bit 0 of the selected shift register. Capture-IR loads 4'b0001, and Capture-DR of the control register loads the current control word. Capture-DR of the bypass loads 0.
- R8: With `trst_n` low at a rising edge of `tck`, the controller goes to Test-Logic-Reset, the control word and the held bit are cleared, and the instruction becomes all ones (bypass). Test-Logic-Reset also sets the instruction to all ones.
- R9: A control word that sets bit 1 during a scan raises `dbgrq_core` in the first cycle in which the controller is in Run-Test/Idle, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, driven on falling `tck` |
| ext_dbgrq | input | 1 | External debug request |
| core_dbgack | input | 1 | Debug acknowledge from the core |
| dbgrq_core | output | 1 | Qualified debug request to the core |
| dbgack_out | output | 1 | Debug acknowledge seen by the system |
| irq_en | output | 1 | Interrupt enable to the core |

## Verification
The bench builds the block with its defaults: a 4-bit instruction register and select code 4'b1100. These values make it possible to switch between the control register and the bypass, and to read the control word back through Capture-DR. The bench arms the request while the controller is away from Run-Test/Idle, then returns through Test-Logic-Reset. This shows that the request is released on the first idle cycle only. The bench also covers interrupt gating under every mix of acknowledge and disable, a bypass scan that must leave the word untouched, the five-TMS-high reset and a test reset in the middle of a scan.

// File: rtl/dbgc_pkg.sv
// Package: shared test-controller state type and its transition function.
// Assumes the standard 16-state controller, advanced on TMS at rising TCK.
package dbgc_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    // Next controller state for a given TMS value.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        unique case (s)
            TS_RESET:  return m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return m ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: return m ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return m ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: return m ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: return m ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return m ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
            default:   return TS_RESET;
        endcase
    endfunction

endpackage

// File: rtl/dbgc_tap.sv
// Module: test access port state controller.
// Advances on rising TCK according to TMS; synchronous active-low reset to
// Test-Logic-Reset. Assumes TMS is stable around the rising edge.
module dbgc_tap
    import dbgc_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    localparam int HI_LIMIT = 5;
    localparam int HI_W     = $clog2(HI_LIMIT + 1);

    tap_state_t   state_q;
    logic [HI_W-1:0] hi_cnt;

    // Controller state register.
    always_ff @(posedge tck) begin
        if (!trst_n) state_q <= TS_RESET;
        else         state_q <= tap_next(state_q, tms);
    end

    // Saturating count of consecutive TMS-high edges, for the reset check.
    always_ff @(posedge tck) begin
        if (!trst_n || !tms)        hi_cnt <= '0;
        else if (hi_cnt < HI_W'(HI_LIMIT)) hi_cnt <= hi_cnt + 1'b1;
    end

    assign state = state_q;

    // R5
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_cnt >= HI_W'(HI_LIMIT)) |-> (state_q == TS_RESET));

    // R8
    trst_state_chk: assert property (@(posedge tck)
        (trst_n === 1'b0) |=> (state_q == TS_RESET));

endmodule

// File: rtl/dbgc_scan.sv
// Module: instruction register, control data register and bypass bit.
// Shifts LSB first, captures and updates per controller state, drives TDO
// on falling TCK. Assumes the controller state comes from dbgc_tap.
module dbgc_scan
    import dbgc_pkg::*;
#(
    parameter int          IR_W     = 4,
    parameter int          CTRL_W   = 3,
    parameter logic [IR_W-1:0] SEL_CODE = 4'b1100
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_t        state,
    input  logic              tdi,
    output logic [CTRL_W-1:0] ctrl,
    output logic              tdo
);

    localparam logic [IR_W-1:0] IR_BYPASS  = '1;
    localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

    logic [IR_W-1:0]   ir_q, ir_sh;
    logic [CTRL_W-1:0] ctrl_q, dr_sh;
    logic              bp_q;
    logic              sel;

    assign sel = (ir_q == SEL_CODE);

    // Instruction capture, shift and update.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_q  <= IR_BYPASS;
            ir_sh <= '0;
        end else begin
            unique case (state)
                TS_RESET:  ir_q  <= IR_BYPASS;
                TS_CAP_IR: ir_sh <= IR_CAPTURE;
                TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                TS_UPD_IR: ir_q  <= ir_sh;
                default: ;
            endcase
        end
    end

    // Control word shift register and holding register, or bypass bit.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ctrl_q <= '0;
            dr_sh  <= '0;
            bp_q   <= 1'b0;
        end else begin
            unique case (state)
                TS_CAP_DR: if (sel) dr_sh <= ctrl_q; else bp_q <= 1'b0;
                TS_SHF_DR: if (sel) dr_sh <= {tdi, dr_sh[CTRL_W-1:1]}; else bp_q <= tdi;
                TS_UPD_DR: if (sel) ctrl_q <= dr_sh;
                default: ;
            endcase
        end
    end

    // Serial output, launched on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n)                 tdo <= 1'b0;
        else if (state == TS_SHF_IR) tdo <= ir_sh[0];
        else if (state == TS_SHF_DR) tdo <= sel ? dr_sh[0] : bp_q;
        else                         tdo <= 1'b0;
    end

    assign ctrl = ctrl_q;

    // R6
    ctrl_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == TS_UPD_DR && sel) |=> $stable(ctrl_q));

    // R7
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_SHF_IR && state != TS_SHF_DR) |-> (tdo == 1'b0));

endmodule

// File: rtl/dbgc_gate.sv
// Module: request hold stage and output forcing/gating.
// The hold stage follows control bit 1 only in Run-Test/Idle (transparent
// within that state) and keeps its value elsewhere. Assumes a 3-bit control
// word: bit 2 interrupt disable, bit 1 force request, bit 0 force acknowledge.
module dbgc_gate
    import dbgc_pkg::*;
#(
    parameter int CTRL_W = 3
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_t        state,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ext_dbgrq,
    input  logic              core_dbgack,
    output logic              dbgrq_core,
    output logic              dbgack_out,
    output logic              irq_en
);

    localparam int B_ACK = 0;
    localparam int B_REQ = 1;
    localparam int B_DIS = 2;

    logic held_q;
    logic in_idle;
    logic req_view;

    assign in_idle = (state == TS_IDLE);

    // Keep the last value of the request bit seen in Run-Test/Idle.
    always_ff @(posedge tck) begin
        if (!trst_n)      held_q <= 1'b0;
        else if (in_idle) held_q <= ctrl[B_REQ];
    end

    // Transparent while idle, holding otherwise.
    always_comb begin
        req_view   = in_idle ? ctrl[B_REQ] : held_q;
        dbgrq_core = ext_dbgrq | req_view;
        dbgack_out = core_dbgack | ctrl[B_ACK];
        irq_en     = ~(dbgack_out | ctrl[B_DIS]);
    end

    // R4
    hold_outside_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !in_idle |=> $stable(held_q));

    // R1
    irq_inhibit_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (core_dbgack || ctrl[B_DIS] || ctrl[B_ACK]) |-> !irq_en);

    // R3
    ext_req_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ext_dbgrq |-> dbgrq_core);

endmodule

// File: rtl/dbgc_top.sv
// Module: debug request and acknowledge control top.
// Connects the test controller, scan registers and output gating.
// Assumes one test clock domain; trst_n is sampled synchronously.
module dbgc_top #(
    parameter int             IR_W     = 4,
    parameter logic [IR_W-1:0] SEL_CODE = 4'b1100
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    input  logic ext_dbgrq,
    input  logic core_dbgack,
    output logic dbgrq_core,
    output logic dbgack_out,
    output logic irq_en
);

    import dbgc_pkg::*;

    localparam int CTRL_W = 3;

    tap_state_t        state;
    logic [CTRL_W-1:0] ctrl;

    dbgc_tap u_tap (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    dbgc_scan #(
        .IR_W     (IR_W),
        .CTRL_W   (CTRL_W),
        .SEL_CODE (SEL_CODE)
    ) u_scan (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ctrl   (ctrl),
        .tdo    (tdo)
    );

    dbgc_gate #(
        .CTRL_W (CTRL_W)
    ) u_gate (
        .tck         (tck),
        .trst_n      (trst_n),
        .state       (state),
        .ctrl        (ctrl),
        .ext_dbgrq   (ext_dbgrq),
        .core_dbgack (core_dbgack),
        .dbgrq_core  (dbgrq_core),
        .dbgack_out  (dbgack_out),
        .irq_en      (irq_en)
    );

    // R9
    idle_release_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_IDLE && !ext_dbgrq && $stable(state) && $past(!dbgrq_core))
        |-> !dbgrq_core);

endmodule

// File: tb/dbgc_top_tb_top.sv
// Bench: behavioural reference model of the controller, scan registers and
// outputs, compared against the design every clock.
module dbgc_top_tb_top;

    localparam int TCK_PERIOD = 20;
    localparam int SEL        = 12;   // 4'b1100
    localparam int IRW        = 4;

    logic tck = 1'b0;
    logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic ext_dbgrq = 1'b0, core_dbgack = 1'b0;
    logic tdo, dbgrq_core, dbgack_out, irq_en;

    int n_run = 0, n_fail = 0, n_cyc = 0;
    string tag = "R7";

    // model state: 0 reset,1 idle,2 seldr,3 capdr,4 shfdr,5 ex1dr,6 paudr,
    // 7 ex2dr,8 upddr,9 selir,10 capir,11 shfir,12 ex1ir,13 pauir,14 ex2ir,15 updir
    int m_st = 0;
    int m_ir = 15, m_irsh = 0, m_dr = 0, m_bp = 0, m_ctrl = 0, m_held = 0;

    dbgc_top dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .ext_dbgrq(ext_dbgrq), .core_dbgack(core_dbgack),
        .dbgrq_core(dbgrq_core), .dbgack_out(dbgack_out), .irq_en(irq_en)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    always @(posedge tck) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not end (got %0d cycles, expected < 20000)", n_cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input int exp);
        n_run++;
        if (act !== exp[0]) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int s, input logic m);
        int t[16][2] = '{'{1,0},'{1,2},'{3,9},'{4,5},'{4,5},'{6,8},'{6,7},'{4,8},
                         '{1,2},'{10,0},'{11,12},'{11,12},'{13,15},'{13,14},'{11,15},'{1,2}};
        return t[s][m];
    endfunction

    function automatic int exp_rq();
        int v = (m_st == 1) ? ((m_ctrl >> 1) & 1) : m_held;
        return int'(ext_dbgrq) | v;
    endfunction
    function automatic int exp_ack();
        return int'(core_dbgack) | (m_ctrl & 1);
    endfunction
    function automatic int exp_irq();
        return ((exp_ack() == 0) && ((m_ctrl >> 2) & 1) == 0) ? 1 : 0;
    endfunction

    task automatic check_comb();
        chk("R1", irq_en, exp_irq());
        chk("R2", dbgack_out, exp_ack());
        chk("R3", dbgrq_core, exp_rq());
    endtask

    // Reference update at a rising edge.
    task automatic model_edge();
        if (!trst_n) begin
            m_st = 0; m_ir = 15; m_irsh = 0; m_dr = 0; m_bp = 0; m_ctrl = 0; m_held = 0;
            return;
        end
        if (m_st == 1) m_held = (m_ctrl >> 1) & 1;
        case (m_st)
            0:  m_ir = 15;
            10: m_irsh = 1;
            11: m_irsh = (m_irsh >> 1) | (int'(tdi) << (IRW-1));
            15: m_ir = m_irsh;
            3:  if (m_ir == SEL) m_dr = m_ctrl; else m_bp = 0;
            4:  if (m_ir == SEL) m_dr = (m_dr >> 1) | (int'(tdi) << 2); else m_bp = int'(tdi);
            8:  if (m_ir == SEL) m_ctrl = m_dr;
            default: ;
        endcase
        m_st = nxt(m_st, tms);
    endtask

    // One TCK cycle: check TDO after the falling edge, drive, check after rising edge.
    task automatic step(input logic m, input logic d);
        int e;
        @(negedge tck); #1;
        if (!trst_n || (m_st != 4 && m_st != 11)) e = 0;
        else if (m_st == 11) e = m_irsh & 1;
        else e = (m_ir == SEL) ? (m_dr & 1) : m_bp;
        chk(tag, tdo, e);
        tms = m; tdi = d;
        @(posedge tck); #1;
        model_edge();
        check_comb();
    endtask

    // From idle: load an instruction, finish in idle.
    task automatic load_ir(input int code);
        step(1,0); step(1,0); step(0,0); step(0,0);
        for (int i = 0; i < IRW; i++) step(i == IRW-1, code[i]);
        step(1,0); step(0,0);
    endtask

    // From idle: scan 3 data bits; end in idle (to_idle) or in Select-DR.
    task automatic scan_dr(input int val, input bit to_idle);
        step(1,0); step(0,0); step(0,0);
        for (int i = 0; i < 3; i++) step(i == 2, val[i]);
        step(1,0); step(!to_idle, 0);
    endtask

    initial begin
        repeat (3) step(1, 0);
        // R8 reset state: irq_en follows inverse of core_dbgack
        chk("R8", irq_en, 1); chk("R8", dbgrq_core, 0); chk("R8", dbgack_out, 0);
        core_dbgack = 1; #1; check_comb(); chk("R1", irq_en, 0);
        core_dbgack = 0;
        trst_n = 1'b1;
        step(0,0); step(0,0);

        tag = "R6";
        load_ir(SEL);
        // R9: arm request but leave via Select-DR, not idle
        scan_dr(3'b010, 0);
        chk("R9", dbgrq_core, 0);
        step(1,0);                         // Select-IR
        chk("R4", dbgrq_core, 0);
        step(1,0);                         // Test-Logic-Reset
        chk("R4", dbgrq_core, 0);
        step(0,0);                         // Run-Test/Idle: release
        chk("R9", dbgrq_core, 1);
        // TLR put IR back to bypass (R8), so reload selection
        load_ir(SEL);
        scan_dr(3'b000, 0);                // leave through Select-DR
        chk("R4", dbgrq_core, 1);          // held value remains
        step(1,0); step(1,0); step(0,0);
        chk("R4", dbgrq_core, 0);

        // R2 forced ack, R1 gating
        load_ir(SEL);
        scan_dr(3'b001, 1);
        chk("R2", dbgack_out, 1); chk("R1", irq_en, 0);
        scan_dr(3'b100, 1);
        chk("R1", irq_en, 0); chk("R2", dbgack_out, 0);
        ext_dbgrq = 1; #1; check_comb(); chk("R3", dbgrq_core, 1);
        ext_dbgrq = 0;
        scan_dr(3'b000, 1);
        chk("R1", irq_en, 1);
        core_dbgack = 1; #1; check_comb(); core_dbgack = 0;

        // R6: bypass leaves the word unchanged; read back by capture
        scan_dr(3'b101, 1);
        tag = "R7";
        load_ir(3);
        scan_dr(3'b010, 1);
        chk("R6", dbgack_out, 1); chk("R6", irq_en, 0); chk("R6", dbgrq_core, 0);
        load_ir(SEL);
        tag = "R6";
        scan_dr(3'b101, 1);                // readback of 101 checked on tdo

        // R5: five TMS-high edges reach reset, IR back to bypass
        for (int i = 0; i < 5; i++) step(1,0);
        step(0,0);
        tag = "R5";
        scan_dr(3'b011, 1);                // bypass: control unchanged
        chk("R5", dbgack_out, 1); chk("R5", dbgrq_core, 0);

        // R8: test reset during a scan
        load_ir(SEL);
        step(1,0); step(0,0); step(0,1);
        trst_n = 0; step(0,1); trst_n = 1;
        chk("R8", dbgack_out, 0); chk("R8", irq_en, 1); chk("R8", dbgrq_core, 0);
        step(0,0); step(0,0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule